// File: doc/BRIEF.md
# Four-Stage Chained Streaming NTT Engine

This block computes an n-point number-theoretic transform over a prime modulus Q. It uses four butterfly stages wired in a chain, and each stage has a single-path delay-feedback loop. The engine works in decimation-in-frequency order. The first stage delays by n/2 samples, and each stage after it delays by half as much as the stage before. Samples enter one per clock and leave one per clock.

When log2(n) is greater than four, the same four stages are used again in further passes. Between passes, the results wait in a holding store that is separate from the caller's memory and is one polynomial deep. The delay lengths keep halving from the point where the previous pass stopped. Stages that have no work left in the final pass pass their data straight through.

Operation is started by a one-cycle `start` pulse. The engine then reads the polynomial through a read port with one cycle of latency. Results leave the block in bit-reversed position order, and they are not reordered. The twiddle factor for each stage comes from a small power table of a root of unity ω. The table is addressed by the stage's position within its block and scaled by the stage's depth in the transform.

Top module: `ntt_chain4`

## Requirements
- R1: After reset, `busy`, `mem_rd_en`, `out_valid` and `done` are all 0, and they stay 0 until `start` is seen.
- R2: The result at output position p (0 first) equals X[k] = Σ x[j]·ω^(j·k) mod Q, where k is p with its log2(n) bits reversed, ω^(n/2) = Q−1, and every value lies in [0, Q).
- R3: Each transform emits exactly n results on consecutive cycles. `done` is high for one cycle, in the same cycle as the last result.
- R4: `done` appears (P+1)·n cycles after the clock edge that accepts `start`, where P = ceil(log2(n)/4) is the number of passes.
- R5: Each transform raises `mem_rd_en` in exactly n cycles. The addresses are 0, 1, …, n−1 in order, and the word for an address is taken from `mem_rd_data` one cycle after it is requested.
- R6: A `start` pulse that arrives while `busy` is high has no effect. The running transform's results and timing are unchanged.
- R7: In pass p, stage s delays by n >> (1+4p+s) samples. A stage whose delay works out to zero forwards its input unchanged, so a two-pass n=64 transform bypasses the last two stages of pass 1.
- R8: A `start` given in the first cycle after `done` begins a new transform, and no data from the previous transform appears in its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a transform |
| busy | output | 1 | High while a transform is being read or computed |
| mem_rd_en | output | 1 | Read request to the polynomial memory |
| mem_rd_addr | output | log2(N) | Read address, coefficient index |
| mem_rd_data | input | W | Coefficient returned one cycle after the request |
| out_valid | output | 1 | A result is present on `out_data` |
| out_data | output | W | Result in bit-reversed position order |
| done | output | 1 | Marks the last result of a transform |

## Verification
Two things can meet in one clock edge: the last result of a transform is registered and the sequencer returns to idle, so a new `start` can be accepted in the very next cycle. The bench provokes this with back-to-back transforms whose inputs differ widely, such as all-maximum values followed by a pattern full of zeros. It judges the result by comparing every output of the second transform with its own reference and by checking that its latency matches. A second collision places a `start` pulse in the middle of a running transform; that case passes only if the outputs and the `done` cycle are identical to an undisturbed run.

// File: rtl/ntt_chain_pkg.sv
package ntt_chain_pkg;
  localparam int NSTG = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} seq_st_e;
endpackage

// File: rtl/ntt_tw_rom.sv
module ntt_tw_rom #(
  parameter int W     = 8,
  parameter int Q     = 193,
  parameter int OMEGA = 125,
  parameter int N     = 64,
  parameter int TW    = 5,
  parameter int NP    = 4
) (
  input  logic [NP-1:0][TW-1:0] idx,
  output logic [NP-1:0][W-1:0]  val
);
  localparam int NE = N / 2;
  localparam logic [2*W-1:0] QQ = (2*W)'(Q);
  localparam logic [2*W-1:0] OM = (2*W)'(OMEGA);

  // power table omega^e, e = 0 .. n/2-1, built from constants
  logic [W-1:0] tab [NE];
  assign tab[0] = W'(1);
  for (genvar e = 1; e < NE; e++) begin : g_pow
    assign tab[e] = W'(({{W{1'b0}}, tab[e-1]} * OM) % QQ);
  end

  for (genvar s = 0; s < NP; s++) begin : g_port
    assign val[s] = tab[idx[s]];
  end
endmodule

// File: rtl/ntt_sdf_stage.sv
module ntt_sdf_stage #(
  parameter int W    = 8,
  parameter int Q    = 193,
  parameter int LMAX = 32,
  parameter int LW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] len,
  input  logic          upper,
  input  logic [W-1:0]  tw,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam logic [W:0]     QX = (W+1)'(Q);
  localparam logic [W-1:0]   QW = W'(Q);
  localparam logic [2*W-1:0] QQ = (2*W)'(Q);

  logic [W-1:0]   dly [LMAX];
  logic [W-1:0]   head, diff, prod_m, sum, push;
  logic [W:0]     sraw;
  logic [2*W-1:0] prod;
  logic           byp;

  // delay-line tap at the current length
  always_comb begin
    head = dly[0];
    for (int i = 0; i < LMAX; i++)
      if (LW'(i + 1) == len) head = dly[i];
  end

  always_comb begin
    byp    = (len == '0);
    sraw   = {1'b0, head} + {1'b0, din};
    sum    = (sraw >= QX) ? W'(sraw - QX) : W'(sraw);
    diff   = (head >= din) ? head - din : head + QW - din;
    prod   = {{W{1'b0}}, diff} * {{W{1'b0}}, tw};
    prod_m = W'(prod % QQ);
    push   = (upper && !byp) ? prod_m : din;
    dout   = byp ? din : (upper ? sum : head);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      dly[0] <= push;
      for (int i = 1; i < LMAX; i++) dly[i] <= dly[i-1];
    end
  end

  // R7: the sequencer never asks for a delay beyond this stage's line
  a_r7_len_fits: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(len) <= LMAX));
endmodule

// File: rtl/ntt_pass_ctrl.sv
module ntt_pass_ctrl
  import ntt_chain_pkg::*;
#(
  parameter int N    = 64,
  parameter int LOGN = 6,
  parameter int TW   = 5,
  parameter int PW   = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        fst,
  output logic                        lst,
  output logic [NSTG-1:0][LOGN-1:0]   len,
  output logic [NSTG-1:0]             upper,
  output logic [NSTG-1:0][TW-1:0]     tidx,
  output logic                        emit,
  output logic                        fin,
  output logic [LOGN-1:0]             widx,
  output logic [LOGN-1:0]             ridx,
  output logic                        rd_en,
  output logic [LOGN-1:0]             rd_addr
);
  localparam int CW    = LOGN + 1;
  localparam int NPASS = (LOGN + 3) / 4;

  seq_st_e        st, st_n;
  logic [PW-1:0]  pass, pass_n;
  logic [CW-1:0]  c, c_n, dtot, last_c, acc;
  logic [LOGN-1:0] k, j;
  int             sh;

  // per-stage delay length, phase and twiddle index
  always_comb begin
    acc = '0;
    for (int s = 0; s < NSTG; s++) begin
      sh = 4 * int'(pass) + s;
      len[s]   = (sh + 1 > LOGN) ? '0 : LOGN'(N >> (sh + 1));
      k        = LOGN'(c - acc);
      upper[s] = |(k & len[s]);
      j        = k & (len[s] - 1'b1);
      tidx[s]  = TW'(j << sh);
      acc      = acc + CW'(len[s]);
    end
    dtot = acc;
  end

  always_comb begin
    last_c  = dtot + CW'(N - 1);
    fst     = (pass == '0);
    lst     = (int'(pass) == NPASS - 1);
    busy    = (st != ST_IDLE);
    emit    = (st == ST_RUN) && (c >= dtot) && (c <= last_c);
    fin     = (st == ST_RUN) && lst && (c == last_c);
    widx    = LOGN'(c - dtot);
    ridx    = LOGN'(c);
    rd_en   = (st == ST_PRIME) || ((st == ST_RUN) && fst && (c < CW'(N - 1)));
    rd_addr = (st == ST_PRIME) ? '0 : LOGN'(c + 1'b1);
  end

  always_comb begin
    st_n   = st;
    pass_n = pass;
    c_n    = c;
    case (st)
      ST_IDLE:  if (start) begin st_n = ST_PRIME; pass_n = '0; c_n = '0; end
      ST_PRIME: st_n = ST_RUN;
      ST_RUN: begin
        if (c == last_c) begin
          c_n = '0;
          if (lst) st_n = ST_IDLE;
          else     pass_n = pass + 1'b1;
        end else begin
          c_n = c + 1'b1;
        end
      end
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pass <= '0;
      c    <= '0;
    end else begin
      st   <= st_n;
      pass <= pass_n;
      c    <= c_n;
    end
  end

  // R5: consecutive read requests walk the address space by one
  a_r5_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));
  // R4: the final result ends the transform
  a_r4_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  // R6: a running pass is never cut short, start or not
  a_r6_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RUN) && !fin) |=> busy);
endmodule

// File: rtl/ntt_chain4.sv
module ntt_chain4
  import ntt_chain_pkg::*;
#(
  parameter int W     = 8,
  parameter int Q     = 193,
  parameter int OMEGA = 125,
  parameter int N     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   mem_rd_en,
  output logic [$clog2(N)-1:0]   mem_rd_addr,
  input  logic [W-1:0]           mem_rd_data,
  output logic                   out_valid,
  output logic [W-1:0]           out_data,
  output logic                   done
);
  localparam int LOGN  = $clog2(N);
  localparam int TW    = LOGN - 1;
  localparam int NPASS = (LOGN + 3) / 4;
  localparam int PW    = (NPASS > 1) ? $clog2(NPASS) : 1;

  logic [1:0]                  rsync;
  logic                        rst_core_n;
  logic                        fst, lst, emit, fin;
  logic [NSTG-1:0][LOGN-1:0]   len;
  logic [NSTG-1:0]             upper;
  logic [NSTG-1:0][TW-1:0]     tidx;
  logic [NSTG-1:0][W-1:0]      tw;
  logic [LOGN-1:0]             widx, ridx;
  logic [W-1:0]                link [NSTG+1];
  logic [W-1:0]                hold [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  ntt_pass_ctrl #(.N(N), .LOGN(LOGN), .TW(TW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start(start), .busy(busy),
    .fst(fst), .lst(lst), .len(len), .upper(upper), .tidx(tidx),
    .emit(emit), .fin(fin), .widx(widx), .ridx(ridx),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr));

  ntt_tw_rom #(.W(W), .Q(Q), .OMEGA(OMEGA), .N(N), .TW(TW), .NP(NSTG)) u_rom (
    .idx(tidx), .val(tw));

  // pass source: memory port on the first pass, holding store after
  assign link[0] = fst ? mem_rd_data : hold[ridx];

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int LM = ((N >> (s + 1)) > 0) ? (N >> (s + 1)) : 1;
    ntt_sdf_stage #(.W(W), .Q(Q), .LMAX(LM), .LW(LOGN)) u_stg (
      .clk(clk), .rst_n(rst_core_n), .en(busy), .len(len[s]),
      .upper(upper[s]), .tw(tw[s]), .din(link[s]), .dout(link[s+1]));
  end

  always_ff @(posedge clk) begin
    if (emit && !lst) hold[widx] <= link[NSTG];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit && lst;
      done      <= fin;
      if (emit && lst) out_data <= link[NSTG];
    end
  end

  // R3: done only ever marks a result cycle
  a_r3_done_valid: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> out_valid);
  // R2: every result is a reduced residue
  a_r2_out_range: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (int'(out_data) < Q));
  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> !mem_rd_en);
endmodule

// File: tb/sim_ntt_chain4.sv
`timescale 1ns/1ps
module sim_ntt_chain4;
  localparam int W = 8, Q = 193, OMEGA = 125, N = 64, LOGN = 6, NP = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, mem_rd_en, out_valid, done;
  logic [LOGN-1:0] mem_rd_addr;
  logic [W-1:0] mem_rd_data = '0, out_data;

  int n_cmp = 0, n_bad = 0;
  int mem [N];
  int exp_q [$];
  int got_cnt = 0, rd_cnt = 0, rd_next = 0, rd_bad = 0;
  bit fin_flag = 0;

  always #2.5 clk = ~clk;

  ntt_chain4 #(.W(W), .Q(Q), .OMEGA(OMEGA), .N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_data(out_data), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // polynomial memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= W'(mem[mem_rd_addr]);
      if (int'(mem_rd_addr) != rd_next) rd_bad++;
      rd_next++;
      rd_cnt++;
    end
  end

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_cnt++;
      if (exp_q.size() == 0) chk(0, "R3 unexpected result", int'(out_data), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(out_data) == e, "R2 result", int'(out_data), e);
      end
    end
  end

  function automatic int mpow(input int b, input int e);
    int r = 1;
    for (int i = 0; i < (e % N); i++) r = (r * b) % Q;
    return r;
  endfunction

  function automatic int brev(input int p);
    int r = 0;
    for (int i = 0; i < LOGN; i++) if (p[i]) r |= 1 << (LOGN - 1 - i);
    return r;
  endfunction

  task automatic run_frame(input int kind, input bit poke, input bit b2b);
    int x [N];
    int seed, cyc;
    seed = 17 + kind * 31;
    for (int j = 0; j < N; j++) begin
      case (kind)
        0: x[j] = (j == 0) ? 1 : 0;
        1: x[j] = Q - 1;
        2: x[j] = j % Q;
        4: x[j] = 0;
        5: x[j] = (j == N/2) ? 7 : 0;
        default: begin seed = (seed * 1103 + 12345) % 65521; x[j] = seed % Q; end
      endcase
      mem[j] = x[j];
    end
    // driver: expected results in bit-reversed position order (R2, R7)
    for (int p = 0; p < N; p++) begin
      int k, acc;
      k = brev(p);
      acc = 0;
      for (int j = 0; j < N; j++) acc = (acc + x[j] * mpow(OMEGA, (j * k) % N)) % Q;
      exp_q.push_back(acc);
    end
    got_cnt = 0; rd_cnt = 0; rd_next = 0; rd_bad = 0;
    if (!b2b) @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4 * N * (NP + 1)) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = (poke && (cyc == 40 || cyc == 130));  // R6: pulses while busy
    end
    start = 1'b0;
    #1;
    chk(cyc == (NP + 1) * N, "R4 latency", cyc, (NP + 1) * N);
    chk(out_valid == 1'b1, "R3 done with last result", int'(out_valid), 1);
    chk(got_cnt == N, "R3 result count", got_cnt, N);
    chk(exp_q.size() == 0, "R3 leftover expected", exp_q.size(), 0);
    chk(rd_cnt == N, "R5 read count", rd_cnt, N);
    chk(rd_bad == 0, "R5 address order", rd_bad, 0);
    if (poke) chk(got_cnt == N && cyc == (NP + 1) * N, "R6 start ignored", cyc, (NP + 1) * N);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    chk(!busy && !mem_rd_en && !out_valid && !done, "R1 reset state",
        int'({busy, mem_rd_en, out_valid, done}), 0);
    repeat (5) @(negedge clk);
    chk(!busy && !mem_rd_en, "R1 stays idle", int'({busy, mem_rd_en}), 0);
    run_frame(0, 0, 0);  // impulse
    run_frame(2, 0, 0);  // ramp
    run_frame(3, 0, 0);  // R7: random data through two passes with bypassed stages
    run_frame(5, 1, 0);  // R6: start pulses during a run
    run_frame(1, 0, 0);  // all Q-1
    run_frame(4, 0, 1);  // R8: back-to-back, zeros after all maximum
    run_frame(6, 0, 1);  // R8: back-to-back again
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, "R1 idle at end", int'({busy, out_valid}), 0);
    fin_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule